// File: doc/BRIEF.md
# Carry Flag Bit Manipulation Unit

This block carries out the single-bit instructions of a 16-bit accumulator datapath that work on the carry flag and one selected accumulator bit. It can copy an accumulator bit into carry, copy carry into an accumulator bit, fold an accumulator bit into carry with AND, OR or XOR, and clear, set or complement carry. It also recognises the no-operation code that shares this opcode space, and it flags unused codes in that space as illegal.

Each cycle the pipeline offers an instruction word with a valid strobe, together with the current accumulator and carry. One clock later the block presents the updated accumulator and carry. Write strobes tell the surrounding register file which of the two was actually written. Sign and zero results are produced only when an accumulator bit is written, and they are flagged by the accumulator write strobe. Words outside this opcode space are not claimed, and their values pass through untouched. The accumulator width, the way the bit write is built and the way the zero test is built are parameters.

Top module: `carry_bitop_unit`

## Requirements
- R1: The block claims a valid word when its bits [11:8] and bits [3:0] are both 1010 and its bits [15:12] are one of 1001, 1010, 1011, 1101, 1110 or 1111. `claim_o` is 1 in the next cycle for such a word and 0 for any other word.
- R2: Prefix 1110 copies accumulator bit b into carry, where b = bits [7:4]. It asserts `carry_we_o`.
- R3: Prefix 1111 writes carry into accumulator bit b (b = bits [7:4]) and leaves every other bit unchanged. It asserts `acc_we_o`.
- R4: After a prefix 1111 write, `sign_o` equals bit 15 of the new accumulator and `zero_o` is 1 exactly when the new accumulator is 0.
- R5: Prefixes 1001, 1010 and 1011 set carry to carry AND, OR and XOR accumulator bit b respectively, and assert `carry_we_o`.
- R6: Under prefix 1101, sub-code (bits [7:4]) 0000 clears carry, 0001 sets carry and 0010 complements carry. Each asserts `carry_we_o`.
- R7: Prefix 1101 with sub-code 0011 is a no-operation. It raises `nop_o`, asserts neither write strobe, and passes the accumulator and carry through.
- R8: Prefix 1101 with a sub-code from 0100 to 1111 raises `illegal_o`, asserts neither write strobe, and passes the accumulator and carry through.
- R9: Every claimed operation other than prefix 1111 leaves `acc_o` equal to the input accumulator, keeps `acc_we_o` low and drives `sign_o` and `zero_o` to 0.
- R10: All results are registered, with one clock of latency. If `insn_vld_i` is low, or the word is not claimed, then in the next cycle every strobe is 0 and `acc_o`/`carry_o` equal the inputs.
- R11: A synchronous active-high reset clears `acc_o`, `carry_o` and every strobe and flag output.
- R12: At most one of `nop_o`, `illegal_o`, `carry_we_o` and `acc_we_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_vld_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 16 | Instruction word |
| acc_i | input | DATA_W | Current accumulator |
| carry_i | input | 1 | Current carry flag |
| claim_o | output | 1 | Word belonged to this opcode space |
| carry_o | output | 1 | Updated carry |
| carry_we_o | output | 1 | Carry was written |
| acc_o | output | DATA_W | Updated accumulator |
| acc_we_o | output | 1 | Accumulator, sign and zero were written |
| sign_o | output | 1 | Sign of the new accumulator |
| zero_o | output | 1 | New accumulator is zero |
| nop_o | output | 1 | No-operation code seen |
| illegal_o | output | 1 | Unused sub-code seen |

## Verification
Every output is due exactly one rising edge after the inputs that produced it. That includes the carry, the accumulator, both write strobes, sign, zero, claim, no-operation and illegal. The bench drives the inputs on a falling edge. It compares all outputs against its own model on the next falling edge, after the single register stage has loaded. The reset result is checked the same way, one edge after reset is applied. The checker ties each result to the inputs of the previous cycle with a one-cycle offset.

// File: rtl/cbit_pkg.sv
package cbit_pkg;

   localparam logic [3:0] SPACE_NIB = 4'b1010;

   localparam logic [3:0] PFX_AND  = 4'b1001;
   localparam logic [3:0] PFX_OR   = 4'b1010;
   localparam logic [3:0] PFX_XOR  = 4'b1011;
   localparam logic [3:0] PFX_CTL  = 4'b1101;
   localparam logic [3:0] PFX_LOAD = 4'b1110;
   localparam logic [3:0] PFX_STORE= 4'b1111;

   localparam logic [3:0] SUB_CLR = 4'b0000;
   localparam logic [3:0] SUB_SET = 4'b0001;
   localparam logic [3:0] SUB_CPL = 4'b0010;
   localparam logic [3:0] SUB_NOP = 4'b0011;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_LDC,
      OP_STC,
      OP_ANDC,
      OP_ORC,
      OP_XORC,
      OP_CLRC,
      OP_SETC,
      OP_CPLC,
      OP_NOP,
      OP_ILL
   } cbit_op_e;

   function automatic logic op_writes_carry(cbit_op_e op);
      return (op == OP_LDC)  || (op == OP_ANDC) || (op == OP_ORC) ||
             (op == OP_XORC) || (op == OP_CLRC) || (op == OP_SETC) ||
             (op == OP_CPLC);
   endfunction

endpackage

// File: rtl/cbit_decode.sv
module cbit_decode
   import cbit_pkg::*;
#(
   parameter int INSN_W = 16,
   parameter int IDX_W  = 4
) (
   input  logic              vld_i,
   input  logic [INSN_W-1:0] insn_i,
   output cbit_op_e          op_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam int NIB_W = 4;

   if (INSN_W != 16) begin : g_bad_insn_w
      $error("cbit_decode: INSN_W must be 16");
   end
   if (IDX_W < 1 || IDX_W > NIB_W) begin : g_bad_idx_w
      $error("cbit_decode: IDX_W must lie in 1..4");
   end

   logic [NIB_W-1:0] pfx, mid, sub, low;
   logic             in_space;

   assign pfx      = insn_i[15:12];
   assign mid      = insn_i[11:8];
   assign sub      = insn_i[7:4];
   assign low      = insn_i[3:0];
   assign in_space = vld_i && (mid == SPACE_NIB) && (low == SPACE_NIB);
   assign idx_o    = sub[IDX_W-1:0];

   always_comb begin
      op_o = OP_NONE;
      if (in_space) begin
         unique case (pfx)
            PFX_AND:   op_o = OP_ANDC;
            PFX_OR:    op_o = OP_ORC;
            PFX_XOR:   op_o = OP_XORC;
            PFX_LOAD:  op_o = OP_LDC;
            PFX_STORE: op_o = OP_STC;
            PFX_CTL: begin
               unique case (sub)
                  SUB_CLR: op_o = OP_CLRC;
                  SUB_SET: op_o = OP_SETC;
                  SUB_CPL: op_o = OP_CPLC;
                  SUB_NOP: op_o = OP_NOP;
                  default: op_o = OP_ILL;
               endcase
            end
            default:   op_o = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/cbit_lane.sv
module cbit_lane #(
   parameter int DATA_W        = 16,
   parameter int IDX_W         = 4,
   parameter int WRITE_VARIANT = 0
) (
   input  logic [DATA_W-1:0] acc_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              bit_i,
   output logic              sel_o,
   output logic [DATA_W-1:0] wr_o
);

   localparam int LANES = 1 << IDX_W;

   if (LANES != DATA_W) begin : g_bad_lanes
      $error("cbit_lane: DATA_W must equal 2**IDX_W");
   end
   if (WRITE_VARIANT < 0 || WRITE_VARIANT > 1) begin : g_bad_variant
      $error("cbit_lane: WRITE_VARIANT must be 0 or 1");
   end

   logic [DATA_W-1:0] hit;

   for (genvar g = 0; g < DATA_W; g++) begin : g_hit
      assign hit[g] = (idx_i == IDX_W'(g));
   end

   assign sel_o = |(acc_i & hit);

   if (WRITE_VARIANT == 0) begin : g_write_lanes
      for (genvar g = 0; g < DATA_W; g++) begin : g_bit
         assign wr_o[g] = hit[g] ? bit_i : acc_i[g];
      end
   end else begin : g_write_mask
      logic [DATA_W-1:0] mask;
      assign mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx_i;
      assign wr_o = (acc_i & ~mask) | ({DATA_W{bit_i}} & mask);
   end

endmodule

// File: rtl/cbit_flags.sv
module cbit_flags #(
   parameter int DATA_W    = 16,
   parameter int ZERO_TREE = 1
) (
   input  logic [DATA_W-1:0] val_i,
   output logic              sign_o,
   output logic              zero_o
);

   localparam int GRP   = 4;
   localparam int NGRP  = (DATA_W + GRP - 1) / GRP;
   localparam int PAD_W = NGRP * GRP;

   assign sign_o = val_i[DATA_W-1];

   if (ZERO_TREE != 0) begin : g_tree
      logic [PAD_W-1:0] padded;
      logic [NGRP-1:0]  grp_any;
      assign padded = PAD_W'(val_i);
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp_any[g] = |padded[g*GRP +: GRP];
      end
      assign zero_o = ~|grp_any;
   end else begin : g_flat
      assign zero_o = (val_i == '0);
   end

endmodule

// File: rtl/carry_bitop_unit.sv
module carry_bitop_unit
   import cbit_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int WRITE_VARIANT = 0,
   parameter int ZERO_TREE     = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              insn_vld_i,
   input  logic [15:0]       insn_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              carry_i,
   output logic              claim_o,
   output logic              carry_o,
   output logic              carry_we_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              acc_we_o,
   output logic              sign_o,
   output logic              zero_o,
   output logic              nop_o,
   output logic              illegal_o
);

   localparam int IDX_W = $clog2(DATA_W);

   if (DATA_W < 2 || DATA_W > 16 || (1 << IDX_W) != DATA_W) begin : g_bad_w
      $error("carry_bitop_unit: DATA_W must be a power of two from 2 to 16");
   end

   cbit_op_e          op;
   logic [IDX_W-1:0]  idx;
   logic              sel;
   logic [DATA_W-1:0] acc_wr;
   logic              wr_sign, wr_zero;

   cbit_decode #(.INSN_W(16), .IDX_W(IDX_W)) i_dec (
      .vld_i (insn_vld_i),
      .insn_i(insn_i),
      .op_o  (op),
      .idx_o (idx)
   );

   cbit_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WRITE_VARIANT(WRITE_VARIANT)) i_lane (
      .acc_i(acc_i),
      .idx_i(idx),
      .bit_i(carry_i),
      .sel_o(sel),
      .wr_o (acc_wr)
   );

   cbit_flags #(.DATA_W(DATA_W), .ZERO_TREE(ZERO_TREE)) i_flags (
      .val_i (acc_wr),
      .sign_o(wr_sign),
      .zero_o(wr_zero)
   );

   logic              c_nxt;
   logic              store;
   logic [DATA_W-1:0] a_nxt;

   always_comb begin
      unique case (op)
         OP_LDC:  c_nxt = sel;
         OP_ANDC: c_nxt = carry_i & sel;
         OP_ORC:  c_nxt = carry_i | sel;
         OP_XORC: c_nxt = carry_i ^ sel;
         OP_CLRC: c_nxt = 1'b0;
         OP_SETC: c_nxt = 1'b1;
         OP_CPLC: c_nxt = ~carry_i;
         default: c_nxt = carry_i;
      endcase
   end

   assign store = (op == OP_STC);
   assign a_nxt = store ? acc_wr : acc_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         claim_o    <= 1'b0;
         carry_o    <= 1'b0;
         carry_we_o <= 1'b0;
         acc_o      <= '0;
         acc_we_o   <= 1'b0;
         sign_o     <= 1'b0;
         zero_o     <= 1'b0;
         nop_o      <= 1'b0;
         illegal_o  <= 1'b0;
      end else begin
         claim_o    <= (op != OP_NONE);
         carry_o    <= c_nxt;
         carry_we_o <= op_writes_carry(op);
         acc_o      <= a_nxt;
         acc_we_o   <= store;
         sign_o     <= store & wr_sign;
         zero_o     <= store & wr_zero;
         nop_o      <= (op == OP_NOP);
         illegal_o  <= (op == OP_ILL);
      end
   end

endmodule

// File: rtl/cbit_unit_chk.sv
module cbit_unit_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              insn_vld_i,
   input logic [15:0]       insn_i,
   input logic [DATA_W-1:0] acc_i,
   input logic              carry_i,
   input logic              claim_o,
   input logic              carry_o,
   input logic              carry_we_o,
   input logic [DATA_W-1:0] acc_o,
   input logic              acc_we_o,
   input logic              sign_o,
   input logic              zero_o,
   input logic              nop_o,
   input logic              illegal_o
);

   localparam int IDX_W = $clog2(DATA_W);

   logic              in_space;
   logic [3:0]        pfx, sub;
   logic [IDX_W-1:0]  b;
   logic              src_bit;
   logic [DATA_W-1:0] wr_ref;

   assign in_space = insn_vld_i && insn_i[11:8] == 4'b1010 && insn_i[3:0] == 4'b1010;
   assign pfx      = insn_i[15:12];
   assign sub      = insn_i[7:4];
   assign b        = insn_i[4 +: IDX_W];
   assign src_bit  = acc_i[b];
   assign wr_ref   = (acc_i & ~(DATA_W'(1) << b)) | (DATA_W'(carry_i) << b);

   p_load_carry_r2: assert property (@(posedge clk) disable iff (rst)
      (in_space && pfx == 4'b1110) |=> (carry_we_o && carry_o == $past(src_bit)));

   p_store_bit_r3: assert property (@(posedge clk) disable iff (rst)
      (in_space && pfx == 4'b1111) |=> (acc_we_o && acc_o == $past(wr_ref)));

   p_sign_zero_r4: assert property (@(posedge clk) disable iff (rst)
      acc_we_o |-> (sign_o == acc_o[DATA_W-1] && zero_o == (acc_o == '0)));

   p_illegal_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (in_space && pfx == 4'b1101 && sub > 4'b0011) |=>
      (illegal_o && !carry_we_o && !acc_we_o && carry_o == $past(carry_i)));

   p_acc_untouched_r9: assert property (@(posedge clk) disable iff (rst)
      (insn_vld_i && !(in_space && pfx == 4'b1111)) |=>
      (!acc_we_o && !sign_o && !zero_o && acc_o == $past(acc_i)));

   p_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !insn_vld_i |=> (!claim_o && !carry_we_o && !acc_we_o && carry_o == $past(carry_i)));

   p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
      $onehot0({nop_o, illegal_o, carry_we_o, acc_we_o}));

endmodule

bind carry_bitop_unit cbit_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_carry_bitop_unit.sv
module test_carry_bitop_unit;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic          insn_vld_i;
   logic [15:0]   insn_i;
   logic [W-1:0]  acc_i;
   logic          carry_i;
   logic          claim_o, carry_o, carry_we_o, acc_we_o;
   logic          sign_o, zero_o, nop_o, illegal_o;
   logic [W-1:0]  acc_o;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   carry_bitop_unit i_carry_bitop_unit (
      .clk(clk), .rst(rst), .insn_vld_i(insn_vld_i), .insn_i(insn_i),
      .acc_i(acc_i), .carry_i(carry_i), .claim_o(claim_o), .carry_o(carry_o),
      .carry_we_o(carry_we_o), .acc_o(acc_o), .acc_we_o(acc_we_o),
      .sign_o(sign_o), .zero_o(zero_o), .nop_o(nop_o), .illegal_o(illegal_o)
   );

   // packed expectation: claim, carry, cwe, awe, sign, zero, nop, ill, acc
   typedef struct packed {
      logic         claim;
      logic         c;
      logic         cwe;
      logic         awe;
      logic         s;
      logic         z;
      logic         nop;
      logic         ill;
      logic [W-1:0] a;
   } exp_t;

   function automatic exp_t model(logic v, logic [15:0] ins, logic [W-1:0] a, logic c);
      exp_t e;
      logic [3:0] p, sb;
      logic       bt;
      e = '0;
      e.a = a;
      e.c = c;
      p  = ins[15:12];
      sb = ins[7:4];
      bt = a[sb];
      if (v && ins[11:8] == 4'hA && ins[3:0] == 4'hA) begin
         case (p)
            4'h9: begin e.claim = 1; e.cwe = 1; e.c = c & bt; end
            4'hA: begin e.claim = 1; e.cwe = 1; e.c = c | bt; end
            4'hB: begin e.claim = 1; e.cwe = 1; e.c = c ^ bt; end
            4'hE: begin e.claim = 1; e.cwe = 1; e.c = bt; end
            4'hF: begin
               e.claim = 1; e.awe = 1;
               e.a[sb] = c;
               e.s = e.a[W-1];
               e.z = (e.a == 0);
            end
            4'hD: begin
               e.claim = 1;
               case (sb)
                  4'h0: begin e.cwe = 1; e.c = 1'b0; end
                  4'h1: begin e.cwe = 1; e.c = 1'b1; end
                  4'h2: begin e.cwe = 1; e.c = ~c; end
                  4'h3: e.nop = 1;
                  default: e.ill = 1;
               endcase
            end
            default: ;
         endcase
      end
      return e;
   endfunction

   function automatic string tag_of(logic v, logic [15:0] ins);
      if (!v) return "R10";
      if (ins[11:8] != 4'hA || ins[3:0] != 4'hA) return "R1";
      case (ins[15:12])
         4'h9, 4'hA, 4'hB: return "R5";
         4'hE: return "R2";
         4'hF: return "R3/R4";
         4'hD: return (ins[7:4] < 4'h3) ? "R6" : (ins[7:4] == 4'h3) ? "R7" : "R8";
         default: return "R1";
      endcase
   endfunction

   function automatic exp_t got();
      exp_t g;
      g.claim = claim_o; g.c = carry_o; g.cwe = carry_we_o; g.awe = acc_we_o;
      g.s = sign_o; g.z = zero_o; g.nop = nop_o; g.ill = illegal_o; g.a = acc_o;
      return g;
   endfunction

   task automatic compare(exp_t e, string tag);
      exp_t g;
      g = got();
      tests++;
      if (g !== e) begin
         fails++;
         $display("FAIL %s: got claim=%b c=%b cwe=%b awe=%b s=%b z=%b nop=%b ill=%b acc=%h ; expected claim=%b c=%b cwe=%b awe=%b s=%b z=%b nop=%b ill=%b acc=%h",
                  tag, g.claim, g.c, g.cwe, g.awe, g.s, g.z, g.nop, g.ill, g.a,
                  e.claim, e.c, e.cwe, e.awe, e.s, e.z, e.nop, e.ill, e.a);
      end
      if ($countones({g.nop, g.ill, g.cwe, g.awe}) > 1) begin
         fails++;
         $display("FAIL R12: strobes nop=%b ill=%b cwe=%b awe=%b, expected at most one set",
                  g.nop, g.ill, g.cwe, g.awe);
      end
   endtask

   // drive on a falling edge, check on the next falling edge (one register stage)
   task automatic apply(logic v, logic [15:0] ins, logic [W-1:0] a, logic c);
      exp_t e;
      insn_vld_i = v;
      insn_i     = ins;
      acc_i      = a;
      carry_i    = c;
      e = model(v, ins, a, c);
      @(negedge clk);
      compare(e, tag_of(v, ins));
   endtask

   function automatic logic [15:0] mk(logic [3:0] p, logic [3:0] s);
      return {p, 4'hA, s, 4'hA};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      logic [3:0] pf [6];
      void'($urandom(32'h5EED_1234));
      pf[0] = 4'h9; pf[1] = 4'hA; pf[2] = 4'hB; pf[3] = 4'hD; pf[4] = 4'hE; pf[5] = 4'hF;

      // R11: reset with a live store request on the inputs
      rst = 1'b1; insn_vld_i = 1'b1; insn_i = mk(4'hF, 4'h3); acc_i = 16'hBEEF; carry_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      compare('0, "R11");
      rst = 1'b0;

      // R3/R4: write carry=0 into the only set bit -> zero flag
      apply(1'b1, mk(4'hF, 4'h0), 16'h0001, 1'b0);
      // R3/R4: write carry=1 into bit 15 -> sign flag
      apply(1'b1, mk(4'hF, 4'hF), 16'h0000, 1'b1);
      // R3: write of a value already present, middle bit
      apply(1'b1, mk(4'hF, 4'h7), 16'h0080, 1'b1);
      // R2: load top and bottom bits
      apply(1'b1, mk(4'hE, 4'hF), 16'h8000, 1'b0);
      apply(1'b1, mk(4'hE, 4'h0), 16'hFFFE, 1'b1);
      // R5: AND, OR, XOR
      apply(1'b1, mk(4'h9, 4'h4), 16'h0010, 1'b1);
      apply(1'b1, mk(4'hA, 4'h4), 16'h0000, 1'b0);
      apply(1'b1, mk(4'hB, 4'h4), 16'h0010, 1'b1);
      // R6: clear, set, complement
      apply(1'b1, mk(4'hD, 4'h0), 16'h1234, 1'b1);
      apply(1'b1, mk(4'hD, 4'h1), 16'h1234, 1'b0);
      apply(1'b1, mk(4'hD, 4'h2), 16'h1234, 1'b1);
      // R7: no-operation
      apply(1'b1, mk(4'hD, 4'h3), 16'hA5A5, 1'b1);
      // R8: lowest and highest unused sub-codes
      apply(1'b1, mk(4'hD, 4'h4), 16'h5A5A, 1'b0);
      apply(1'b1, mk(4'hD, 4'hF), 16'h5A5A, 1'b1);
      // R1: wrong low nibble, wrong middle nibble, unclaimed prefix
      apply(1'b1, 16'hEA1B, 16'hFFFF, 1'b0);
      apply(1'b1, 16'hFB3A, 16'h0000, 1'b1);
      apply(1'b1, mk(4'h8, 4'h1), 16'h00FF, 1'b1);
      apply(1'b1, mk(4'hC, 4'h0), 16'h00FF, 1'b0);
      // R10: valid low with a claimable word
      apply(1'b0, mk(4'hD, 4'h1), 16'h4321, 1'b0);
      // R9: carry-only op on a zero accumulator keeps sign/zero low
      apply(1'b1, mk(4'hD, 4'h1), 16'h0000, 1'b0);

      // random mix: mostly in-space words, some fully random
      for (int i = 0; i < 1500; i++) begin
         logic [15:0] ins;
         if ($urandom_range(0, 9) < 7)
            ins = mk(pf[$urandom_range(0, 5)], 4'($urandom));
         else
            ins = 16'($urandom);
         apply(($urandom_range(0, 7) != 0), ins, W'($urandom), 1'($urandom));
      end

      // R11 again mid-run
      rst = 1'b1; insn_vld_i = 1'b1; insn_i = mk(4'hD, 4'h1); acc_i = 16'h7777; carry_i = 1'b0;
      @(negedge clk);
      compare('0, "R11");
      rst = 1'b0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule